// File: doc/BRIEF.md
# Two-Gate Overlapped Pulse Generator

This block drives the gates of two power switches that share a single inductor in a two-source buck-boost stage. Each switching period has four back-to-back intervals in a fixed order. First the A gate conducts alone. Then both gates conduct. Then the B gate conducts alone. In the last interval neither gate conducts.

The period length, the on-time of each gate and the overlap time are given as unsigned clock-cycle counts. The block samples these inputs only at the boundary where a new period begins, and it checks that they are consistent before using them. A setting that fails the check is ignored. The running setting then stays in force and a one-cycle error flag is raised.

The block also reports which interval is current and gives a one-cycle strobe on the first cycle of every period. All outputs come from registers.

Top module: `dual_gate_pwm`

## Requirements
- R1: While synchronous reset `rst` is high, both gates are low, `phase` is 3, `period_start` and `cfg_err` are low, and the counter is held at zero. The first clock edge after `rst` is released samples the inputs and begins a period.
- R2: `phase` encodes the interval: 0 = A alone, 1 = both, 2 = B alone, 3 = neither. Within one period, `phase` never decreases.
- R3: `gate_a` is high exactly when `phase` is 0 or 1. `gate_b` is high exactly when `phase` is 1 or 2.
- R4: With an accepted setting (P, A, B, O), a period lasts P cycles. In that period:
  - phase 0 lasts A−O cycles;
  - phase 1 lasts O cycles;
  - phase 2 lasts B−O cycles;
  - phase 3 lasts P−A−B+O cycles.
- R5: `gate_a` rises only in a cycle where `period_start` is high.
- R6: Outside a period start:
  - `gate_b` rises only if `gate_a` was high in the previous cycle;
  - `gate_b` falls only when `gate_a` is already low.
- R7: A setting is accepted only if all of these hold: P ≥ 1, O ≤ A, O ≤ B, and A + B − O ≤ P. A rejected setting leaves the previous one running, and `cfg_err` is high for the single cycle in which `period_start` is high.
- R8: `period_start` is high on the first cycle of every period and on no other cycle.
- R9: Input changes made in the middle of a period have no effect on the outputs until the next period boundary.
- R10: An interval of zero length is skipped. Neither gate shows a one-cycle pulse for it, and `phase` moves straight to the next non-empty interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| per_len | input | CW | Period length in cycles |
| duty_a | input | CW | A gate on-time in cycles |
| duty_b | input | CW | B gate on-time in cycles |
| ovl_len | input | CW | Overlap time in cycles |
| gate_a | output | 1 | A switch gate |
| gate_b | output | 1 | B switch gate |
| phase | output | 2 | Current interval, 0 to 3 |
| period_start | output | 1 | High on the first cycle of each period |
| cfg_err | output | 1 | Rejected setting, one cycle |

## Verification
Two events can land in the same cycle: the period boundary, and the reload or rejection of the setting. The bench provokes this by changing the inputs mid-period, by applying settings that break each validity rule, and by applying a setting with no off interval, where B falls in the same cycle that A rises. A behavioural model in the bench tracks the period counter and the accepted setting, and every output is compared against it on every clock.

// File: rtl/dual_gate_pwm.sv
module dual_gate_pwm #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] per_len,
  input  logic [CW-1:0] duty_a,
  input  logic [CW-1:0] duty_b,
  input  logic [CW-1:0] ovl_len,
  output logic          gate_a,
  output logic          gate_b,
  output logic [1:0]    phase,
  output logic          period_start,
  output logic          cfg_err
);
  localparam int EW = CW + 1;

  logic [CW-1:0] cnt, per_q, a_q, b_q, o_q;
  logic [CW-1:0] cnt_n, per_n, a_n, b_n, o_n, t1_n;
  logic [EW-1:0] sum_ab, lim, t3_n;
  logic          wrap, in_ok, take;
  logic [1:0]    phase_d;

  assign wrap   = (cnt == per_q - 1'b1);
  assign sum_ab = EW'(duty_a) + EW'(duty_b);
  assign lim    = EW'(per_len) + EW'(ovl_len);
  assign in_ok  = (per_len != '0) && (ovl_len <= duty_a) &&
                  (ovl_len <= duty_b) && (sum_ab <= lim);
  assign take   = wrap && in_ok;

  assign per_n = take ? per_len : per_q;
  assign a_n   = take ? duty_a  : a_q;
  assign b_n   = take ? duty_b  : b_q;
  assign o_n   = take ? ovl_len : o_q;
  assign cnt_n = wrap ? '0 : cnt + 1'b1;

  assign t1_n = a_n - o_n;
  assign t3_n = EW'(a_n) + EW'(b_n) - EW'(o_n);

  always_comb begin
    if (cnt_n < t1_n)            phase_d = 2'd0;
    else if (cnt_n < a_n)        phase_d = 2'd1;
    else if (EW'(cnt_n) < t3_n)  phase_d = 2'd2;
    else                         phase_d = 2'd3;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt          <= '0;
      per_q        <= CW'(1);
      a_q          <= '0;
      b_q          <= '0;
      o_q          <= '0;
      gate_a       <= 1'b0;
      gate_b       <= 1'b0;
      phase        <= 2'd3;
      period_start <= 1'b0;
      cfg_err      <= 1'b0;
    end else begin
      cnt          <= cnt_n;
      per_q        <= per_n;
      a_q          <= a_n;
      b_q          <= b_n;
      o_q          <= o_n;
      gate_a       <= (cnt_n < a_n);
      gate_b       <= (cnt_n >= t1_n) && (EW'(cnt_n) < t3_n);
      phase        <= phase_d;
      period_start <= wrap;
      cfg_err      <= wrap && !in_ok;
    end
  end

  assert_gate_phase_R3: assert property (@(posedge clk) disable iff (rst)
    (gate_a == (phase < 2'd2)) && (gate_b == (phase == 2'd1 || phase == 2'd2)));

  assert_phase_order_R2: assert property (@(posedge clk) disable iff (rst)
    !period_start |-> phase >= $past(phase));

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt < per_q);

  assert_a_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_a) |-> period_start);

  assert_b_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_b) && !period_start |-> $past(gate_a));

  assert_b_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_b) && !period_start |-> !gate_a);

  assert_err_edge_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> period_start);

  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> !gate_a && !gate_b && !period_start && !cfg_err);
endmodule

// File: tb/dual_gate_pwm_tb.sv
module dual_gate_pwm_tb;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] per_len = '0, duty_a = '0, duty_b = '0, ovl_len = '0;
  logic gate_a, gate_b, period_start, cfg_err;
  logic [1:0] phase;

  int n_tests = 0, n_fail = 0, cyc = 0;
  int m_cnt = 0, m_per = 1, m_a = 0, m_b = 0, m_o = 0;
  int e_ph = 3, e_st = 0, e_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_gate_pwm #(.CW(CW)) u_dut (
    .clk(clk), .rst(rst), .per_len(per_len), .duty_a(duty_a),
    .duty_b(duty_b), .ovl_len(ovl_len), .gate_a(gate_a), .gate_b(gate_b),
    .phase(phase), .period_start(period_start), .cfg_err(cfg_err));

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // Behavioural reference: period counter plus accepted setting (R4, R7, R9)
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_cnt = 0; m_per = 1; m_a = 0; m_b = 0; m_o = 0;
      e_ph = 3; e_st = 0; e_err = 0;
    end else begin
      bit w, ok;
      int p, a, b, o;
      p = per_len; a = duty_a; b = duty_b; o = ovl_len;
      w = (m_cnt == m_per - 1);
      ok = (p >= 1) && (o <= a) && (o <= b) && (a + b <= p + o);
      if (w && ok) begin m_per = p; m_a = a; m_b = b; m_o = o; end
      e_err = w && !ok;
      e_st = w;
      m_cnt = w ? 0 : m_cnt + 1;
      if (m_cnt < m_a - m_o)               e_ph = 0;
      else if (m_cnt < m_a)                e_ph = 1;
      else if (m_cnt < m_a + m_b - m_o)    e_ph = 2;
      else                                 e_ph = 3;
    end
  end

  always @(negedge clk) begin
    if (cyc > 0 && !done) begin
      check(rst ? "R1 phase" : "R2/R10 phase", phase, e_ph);
      check("R3/R4 gate_a", gate_a, (e_ph < 2) ? 1 : 0);
      check("R3/R6 gate_b", gate_b, (e_ph == 1 || e_ph == 2) ? 1 : 0);
      check("R8 period_start", period_start, e_st);
      check("R7 cfg_err", cfg_err, e_err);
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic apply(int p, int a, int b, int o, int n);
    per_len = CW'(p); duty_a = CW'(a); duty_b = CW'(b); ovl_len = CW'(o);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 gate_a in reset", gate_a, 0);
    check("R1 phase in reset", phase, 3);
    rst = 1'b0;
    apply(10, 6, 5, 2, 40);          // R4 nominal overlap
    apply(10, 3, 4, 0, 30);          // R10 no overlap, phase 1 skipped
    apply(8, 3, 5, 3, 24);           // R10 phase 0 skipped
    apply(8, 5, 5, 2, 24);           // R6 no off interval
    apply(6, 0, 0, 0, 18);           // R10 all off
    apply(6, 4, 2, 3, 18);           // R7 reject: overlap > B
    apply(6, 4, 4, 1, 18);           // R7 reject: sum too large
    apply(0, 0, 0, 0, 12);           // R7 reject: zero period
    apply(12, 7, 6, 3, 5);
    apply(12, 2, 2, 1, 3);           // R9 mid-period change
    apply(12, 9, 9, 6, 40);
    apply(1, 1, 1, 1, 10);           // R8 one-cycle period
    apply(7, 7, 7, 7, 21);           // R4 full overlap
    rst = 1'b1;
    apply(9, 4, 4, 2, 3);            // R1 reset mid-run
    rst = 1'b0;
    apply(9, 4, 4, 2, 30);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule